// File: doc/BRIEF.md
# Instruction Decode Pipeline Stage

This block sits between the fetch and execute stages of a small 16-bit processor. It takes the instruction word held in the fetch/decode pipeline register and splits it into fields. In the same cycle it drives up to three read addresses to an external register file. On the next rising clock edge it captures the decoded operation into the decode/execute pipeline register. The captured state holds the operation code, the condition code, an immediate value, the destination register address, the three operand values that the register file returned, the current status register and the program counter of the instruction.

The supported formats are two register loads with an 8-bit immediate and two loads with a displacement register. The immediate loads place the byte low or high. The displacement loads come as a plain variant and a multiple-select variant. A conditional register-to-register load completes the set. Any other bit pattern decodes to a no-operation. For every recognised instruction the block raises a lock request on its destination register in the decode cycle, so that a later hazard unit can use it. The stall output is reserved and stays low.

Top module: `id_decode_stage`

## Requirements
- R1: While rst_n is low, every registered output clears to zero. ex_op reads 0 (no-operation) and ex_cond reads 000 (always execute). lock_req and stall are low.
- R2: A word with bits [15:13]=100 and bit 12=0 decodes to ex_op=1 (load immediate) with ex_cond=000. rx_addr and ex_dst come from bits [11:8]. ex_imm is bits [7:0] zero-extended into the low byte.
- R3: A word with bits [15:13]=100 and bit 12=1 decodes to ex_op=2 (load immediate high) with ex_cond=000. ex_imm holds bits [7:0] in its upper byte and its low byte is zero. The addresses are the same as in R2.
- R4: A word with bits [15:13]=101 decodes to ex_op=3 (load with displacement). ex_cond comes from bits [12:10]. rx_addr and ex_dst come from bits [7:4] and ry_addr from bits [3:0]. rz_addr is bits [9:8] with its two upper bits zero.
- R5: A word with bits [15:13]=110 decodes to ex_op=4 (multiple-select displacement load), with the same field layout as R4.
- R6: A word with bits [15:11]=00001 decodes to ex_op=5 (register load). ex_cond comes from bits [10:8], rx_addr and ex_dst from bits [7:4], ry_addr from bits [3:0], and rz_addr is 0.
- R7: The read addresses follow the instruction in the same cycle, and any port a format does not use is driven 0. ex_rx, ex_ry and ex_rz hold the data that the register file returned during the decode cycle. ex_imm is 0 for formats without an immediate.
- R8: ex_pc and ex_sr hold the pc_in and sr_in values present during the decode cycle.
- R9: For a recognised instruction, lock_req is high in the decode cycle and lock_addr equals rx_addr. stall stays low.
- R10: Any other pattern decodes to ex_op=0 with ex_cond=000, ex_imm=0 and ex_dst=0. All read addresses are 0 and lock_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr | input | 16 | Instruction word from fetch/decode register |
| pc_in | input | DW | Program counter of that instruction |
| sr_in | input | DW | Current status register value |
| rx_data | input | DW | Register file data for rx_addr |
| ry_data | input | DW | Register file data for ry_addr |
| rz_data | input | DW | Register file data for rz_addr |
| rx_addr | output | AW | First read address |
| ry_addr | output | AW | Second read address |
| rz_addr | output | AW | Third read address |
| lock_req | output | 1 | Request to lock the destination register |
| lock_addr | output | AW | Register to lock |
| stall | output | 1 | Stall request (held low) |
| ex_op | output | 3 | Registered operation code |
| ex_cond | output | 3 | Registered condition code |
| ex_imm | output | DW | Registered immediate |
| ex_dst | output | AW | Registered destination address |
| ex_rx | output | DW | Registered first operand |
| ex_ry | output | DW | Registered second operand |
| ex_rz | output | DW | Registered third operand |
| ex_sr | output | DW | Registered status register |
| ex_pc | output | DW | Registered program counter |

## Verification
A wrong decode of the format or field shows up at once on the read address ports and on the lock outputs, in the same cycle the word is presented. A field taken from the wrong bit range or a byte lane that was not cleared shows up one edge later in the pipeline register. A stale operand or pass-through value also appears one edge later. The reference model predicts both the combinational and the registered view for every word, so such a fault is reported within one clock of the instruction that exposes it.

// File: rtl/id_decode_stage.sv
`timescale 1ns/1ps
module id_decode_stage #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   instr,
  input  logic [DW-1:0] pc_in,
  input  logic [DW-1:0] sr_in,
  input  logic [DW-1:0] rx_data,
  input  logic [DW-1:0] ry_data,
  input  logic [DW-1:0] rz_data,
  output logic [AW-1:0] rx_addr,
  output logic [AW-1:0] ry_addr,
  output logic [AW-1:0] rz_addr,
  output logic          lock_req,
  output logic [AW-1:0] lock_addr,
  output logic          stall,
  output logic [2:0]    ex_op,
  output logic [2:0]    ex_cond,
  output logic [DW-1:0] ex_imm,
  output logic [AW-1:0] ex_dst,
  output logic [DW-1:0] ex_rx,
  output logic [DW-1:0] ex_ry,
  output logic [DW-1:0] ex_rz,
  output logic [DW-1:0] ex_sr,
  output logic [DW-1:0] ex_pc
);
  localparam logic [2:0] OP_NOP   = 3'd0;
  localparam logic [2:0] OP_LDI   = 3'd1;
  localparam logic [2:0] OP_LDIH  = 3'd2;
  localparam logic [2:0] OP_LDD   = 3'd3;
  localparam logic [2:0] OP_LDDM  = 3'd4;
  localparam logic [2:0] OP_LDR   = 3'd5;
  localparam logic [2:0] CND_ALWAYS = 3'b000;

  logic [2:0]    dec_op;
  logic [2:0]    dec_cond;
  logic [DW-1:0] dec_imm;
  logic [AW-1:0] ax, ay, az;

  wire [DW-1:0] imm_lo = DW'(instr[7:0]);
  wire [DW-1:0] imm_hi = DW'({instr[7:0], 8'h00});

  always_comb begin
    dec_op   = OP_NOP;
    dec_cond = CND_ALWAYS;
    dec_imm  = '0;
    ax       = '0;
    ay       = '0;
    az       = '0;
    if (instr[15:13] == 3'b100) begin
      dec_op  = instr[12] ? OP_LDIH : OP_LDI;
      dec_imm = instr[12] ? imm_hi : imm_lo;
      ax      = AW'(instr[11:8]);
    end else if (instr[15:13] == 3'b101 || instr[15:13] == 3'b110) begin
      dec_op   = instr[14] ? OP_LDDM : OP_LDD;
      dec_cond = instr[12:10];
      ax       = AW'(instr[7:4]);
      ay       = AW'(instr[3:0]);
      az       = AW'(instr[9:8]);
    end else if (instr[15:11] == 5'b00001) begin
      dec_op   = OP_LDR;
      dec_cond = instr[10:8];
      ax       = AW'(instr[7:4]);
      ay       = AW'(instr[3:0]);
    end
  end

  assign rx_addr   = ax;
  assign ry_addr   = ay;
  assign rz_addr   = az;
  assign lock_req  = rst_n && (dec_op != OP_NOP);
  assign lock_addr = ax;
  assign stall     = 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_op   <= OP_NOP;
      ex_cond <= CND_ALWAYS;
      ex_imm  <= '0;
      ex_dst  <= '0;
      ex_rx   <= '0;
      ex_ry   <= '0;
      ex_rz   <= '0;
      ex_sr   <= '0;
      ex_pc   <= '0;
    end else begin
      ex_op   <= dec_op;
      ex_cond <= dec_cond;
      ex_imm  <= dec_imm;
      ex_dst  <= ax;
      ex_rx   <= rx_data;
      ex_ry   <= ry_data;
      ex_rz   <= rz_data;
      ex_sr   <= sr_in;
      ex_pc   <= pc_in;
    end
  end
endmodule

// File: rtl/id_decode_stage_chk.sv
`timescale 1ns/1ps
module id_decode_stage_chk #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [15:0]   instr,
  input logic [DW-1:0] pc_in,
  input logic [AW-1:0] rz_addr,
  input logic          lock_req,
  input logic [2:0]    ex_op,
  input logic [DW-1:0] ex_imm,
  input logic [DW-1:0] ex_pc
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (ex_op == 3'd0 && ex_imm == '0));

  // R2
  ldi_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr[15:12] == 4'b1000 |=> (ex_op == 3'd1 && ex_imm == DW'($past(instr[7:0]))));

  // R3
  ldi_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr[15:12] == 4'b1001 |=> (ex_op == 3'd2 && ex_imm == DW'({$past(instr[7:0]), 8'h00})));

  // R4
  disp_rz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr[15:13] == 3'b101 |-> rz_addr == AW'(instr[9:8]));

  // R8
  pc_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ex_pc == $past(pc_in));

  // R10
  unknown_nolock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[15:13] == 3'b111 || instr[15:11] == 5'b00000) |-> !lock_req);
endmodule

bind id_decode_stage id_decode_stage_chk #(.DW(DW), .AW(AW)) u_chk (.*);

// File: tb/id_decode_stage_tb.sv
`timescale 1ns/1ps
module id_decode_stage_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] instr = 16'h0000;
  logic [15:0] pc_in = 16'h0000, sr_in = 16'h0000;
  logic [15:0] rx_data, ry_data, rz_data;
  logic [3:0]  rx_addr, ry_addr, rz_addr, lock_addr, ex_dst;
  logic        lock_req, stall;
  logic [2:0]  ex_op, ex_cond;
  logic [15:0] ex_imm, ex_rx, ex_ry, ex_rz, ex_sr, ex_pc;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] rf(input logic [3:0] a);
    return {4'hA, a, 4'h5, ~a};
  endfunction
  assign rx_data = rf(rx_addr);
  assign ry_data = rf(ry_addr);
  assign rz_data = rf(rz_addr);

  id_decode_stage u_dut (
    .clk(clk), .rst_n(rst_n), .instr(instr), .pc_in(pc_in), .sr_in(sr_in),
    .rx_data(rx_data), .ry_data(ry_data), .rz_data(rz_data),
    .rx_addr(rx_addr), .ry_addr(ry_addr), .rz_addr(rz_addr),
    .lock_req(lock_req), .lock_addr(lock_addr), .stall(stall),
    .ex_op(ex_op), .ex_cond(ex_cond), .ex_imm(ex_imm), .ex_dst(ex_dst),
    .ex_rx(ex_rx), .ex_ry(ex_ry), .ex_rz(ex_rz), .ex_sr(ex_sr), .ex_pc(ex_pc)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference decode, written from the requirement text
  task automatic model(input logic [15:0] w, output int op, output int cnd,
                       output int imm, output int ax, output int ay, output int az);
    int top3, top5;
    top3 = int'(w >> 13);
    top5 = int'(w >> 11);
    op = 0; cnd = 0; imm = 0; ax = 0; ay = 0; az = 0;
    if (top3 == 4) begin
      ax = (w >> 8) & 15;
      if (w[12]) begin op = 2; imm = (w & 255) * 256; end
      else begin op = 1; imm = w & 255; end
    end else if (top3 == 5 || top3 == 6) begin
      op = (top3 == 5) ? 3 : 4;
      cnd = (w >> 10) & 7;
      ax = (w >> 4) & 15; ay = w & 15; az = (w >> 8) & 3;
    end else if (top5 == 1) begin
      op = 5; cnd = (w >> 8) & 7;
      ax = (w >> 4) & 15; ay = w & 15;
    end
  endtask

  task automatic step(input logic [15:0] w, input string tag);
    int op, cnd, imm, ax, ay, az;
    logic [15:0] pcv, srv;
    @(negedge clk);
    instr = w;
    pcv = pc_in + 16'h0002; pc_in = pcv;
    srv = sr_in ^ 16'h5A3C ^ w; sr_in = srv;
    #0.5;
    model(w, op, cnd, imm, ax, ay, az);
    check({tag, " rx_addr R7"}, rx_addr, ax);
    check({tag, " ry_addr R7"}, ry_addr, ay);
    check({tag, " rz_addr R7"}, rz_addr, az);
    check({tag, " lock_req R9 R10"}, lock_req, op != 0);
    if (op != 0) check({tag, " lock_addr R9"}, lock_addr, ax);
    check({tag, " stall R9"}, stall, 0);
    @(posedge clk);
    #1;
    check({tag, " ex_op"}, ex_op, op);
    check({tag, " ex_cond"}, ex_cond, cnd);
    check({tag, " ex_imm R7"}, ex_imm, imm);
    check({tag, " ex_dst"}, ex_dst, ax);
    check({tag, " ex_rx R7"}, ex_rx, rf(4'(ax)));
    check({tag, " ex_ry R7"}, ex_ry, rf(4'(ay)));
    check({tag, " ex_rz R7"}, ex_rz, rf(4'(az)));
    check({tag, " ex_pc R8"}, ex_pc, pcv);
    check({tag, " ex_sr R8"}, ex_sr, srv);
  endtask

  task automatic check_reset(input string tag);
    check({tag, " R1 ex_op"}, ex_op, 0);
    check({tag, " R1 ex_cond"}, ex_cond, 0);
    check({tag, " R1 ex_imm"}, ex_imm, 0);
    check({tag, " R1 ex_dst"}, ex_dst, 0);
    check({tag, " R1 operands"}, {ex_rx, ex_ry, ex_rz}, 0);
    check({tag, " R1 pc/sr"}, {ex_pc, ex_sr}, 0);
    check({tag, " R1 lock_req"}, lock_req, 0);
    check({tag, " R1 stall"}, stall, 0);
  endtask

  initial begin
    instr = 16'h8155;
    repeat (3) @(posedge clk);
    #1;
    check_reset("reset");
    @(negedge clk);
    rst_n = 1'b1;
    step(16'h8155, "R2 ldi");
    step(16'h8A00, "R2 ldi zero");
    step(16'h91AA, "R3 ldih");
    step(16'h9FFF, "R3 ldih max");
    step(16'hA312, "R4 disp");
    step(16'hB4F0, "R4 disp cond5");
    step(16'hC312, "R5 dispms");
    step(16'hDFAB, "R5 dispms cond7");
    step(16'h0921, "R6 ld_reg nz");
    step(16'h0F3C, "R6 ld_reg cond7");
    step(16'h0000, "R10 zero");
    step(16'h07FF, "R10 00000");
    step(16'hE123, "R10 111");
    step(16'h1234, "R10 0001");
    begin
      logic [15:0] lf = 16'hACE1;
      for (int i = 0; i < 300; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        step(lf, "mix");
      end
    end
    @(negedge clk);
    instr = 16'h9155;
    rst_n = 1'b0;
    #1;
    check_reset("mid reset");
    @(posedge clk);
    #1;
    check_reset("held reset");
    @(negedge clk);
    rst_n = 1'b1;
    step(16'hA7C9, "R4 after reset");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule